// File: doc/BRIEF.md
# Dual-Queue Keyboard Controller Data Port

This block is the receive side of a PC keyboard controller's data port. It holds two circular byte queues, one filled by the keyboard and one filled by the auxiliary pointing device. Each producer has its own push interface. A host read request takes one byte, and the keyboard queue always has priority. When the keyboard queue is empty, the byte comes from the auxiliary queue.

When both queues are dry, the port does not return a constant. It returns the keyboard byte that was consumed most recently. It finds that byte by reading the keyboard storage one slot behind the read pointer, and it wraps to the last slot when the pointer is at zero. Such a read moves no pointer and no count, so a host that polls an idle port keeps seeing the last key code. Every read answers one cycle later with a data byte and a tag that says where the byte came from.

Top module: `kbd_dual_rx_port`

## Requirements
- R1: After a synchronous reset, `rd_valid_o` is low and both queues are empty. The first read is therefore answered with source tag 2 (repeat).
- R2: A read while the keyboard queue holds data returns its oldest byte with source tag 0. `rd_valid_o` and the data appear in the cycle after the request.
- R3: A read while the keyboard queue is empty and the auxiliary queue holds data returns the oldest auxiliary byte with source tag 1. A keyboard push in the same cycle as the read is not visible to that read.
- R4: A read while both queues are empty returns the keyboard byte stored one slot before the keyboard read pointer, with source tag 2.
- R5: When the keyboard read pointer is 0, the repeat read of R4 uses slot DEPTH-1.
- R6: A repeat read changes no pointer and no count. Consecutive repeat reads return the same byte, and later pushes come out in order.
- R7: Each queue delivers bytes in push order, and its pointers wrap past DEPTH-1 to 0.
- R8: A push into a queue that holds DEPTH bytes, with no pop in the same cycle, is dropped.
- R9: A push and a pop on the same queue in the same cycle leave its count unchanged. This holds even when the queue is full, so that push is kept.
- R10: `rd_valid_o` is high exactly in the cycles that follow a cycle with `rd_req_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_push_i | input | 1 | Push strobe for the keyboard queue |
| kb_data_i | input | DATA_W | Byte pushed into the keyboard queue |
| aux_push_i | input | 1 | Push strobe for the auxiliary queue |
| aux_data_i | input | DATA_W | Byte pushed into the auxiliary queue |
| rd_req_i | input | 1 | Host read request, one byte per cycle |
| rd_valid_o | output | 1 | Read answer valid, one cycle after the request |
| rd_data_o | output | DATA_W | Byte returned for the read |
| rd_src_o | output | 2 | Source of the byte: 0 keyboard, 1 auxiliary, 2 repeat |

## Verification
Every read result is due exactly one clock edge after the request: the request is sampled at that edge, and data, source tag and valid are registered at the same edge. The driver sets inputs on the falling edge, and a pure model of both queues decides the expected answer at that point. The model uses the queue state from before the edge and applies same-cycle pushes after the pop. The monitor wakes shortly after each rising edge. It takes one expected entry for each valid it sees and treats any valid without a pending read as an error, which pins the one-cycle latency.

// File: rtl/kbdq_pkg.sv
package kbdq_pkg;
  typedef enum logic [1:0] {
    SRC_KBD    = 2'd0,
    SRC_AUX    = 2'd1,
    SRC_REPLAY = 2'd2
  } kbdq_src_e;

  localparam int NUM_QUEUES = 2;
  localparam int Q_KBD      = 0;
  localparam int Q_AUX      = 1;
endpackage

// File: rtl/kbdq_ring.sv
module kbdq_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              peek_prev_i,
  output logic              empty_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr, rptr_prev, rd_addr;
  logic [CNT_W-1:0]  cnt;
  logic              full, pop_ok, push_ok;

  assign empty_o   = (cnt == '0);
  assign full      = (cnt == CNT_W'(DEPTH));
  assign pop_ok    = pop_i && !empty_o;
  assign push_ok   = push_i && (!full || pop_ok);
  assign rptr_prev = (rptr == '0) ? LAST : rptr - PTR_W'(1);
  assign rd_addr   = peek_prev_i ? rptr_prev : rptr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (pop_ok || peek_prev_i) rd_data_o <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + PTR_W'(1);
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + PTR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && !pop_i) |=> ($stable(wptr) && cnt == CNT_W'(DEPTH)));

  // R9
  push_pop_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !empty_o) |=> $stable(cnt));

  // R6
  peek_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (peek_prev_i && !pop_i && !push_i) |=> ($stable(rptr) && $stable(cnt)));
endmodule

// File: rtl/kbdq_pick.sv
module kbdq_pick
  import kbdq_pkg::*;
(
  input  logic      rd_req_i,
  input  logic      kb_empty_i,
  input  logic      aux_empty_i,
  output logic      kb_pop_o,
  output logic      aux_pop_o,
  output logic      kb_prev_o,
  output kbdq_src_e src_o
);
  always_comb begin
    kb_pop_o  = 1'b0;
    aux_pop_o = 1'b0;
    kb_prev_o = 1'b0;
    src_o     = SRC_KBD;
    if (!kb_empty_i) begin
      kb_pop_o = rd_req_i;
    end else if (!aux_empty_i) begin
      aux_pop_o = rd_req_i;
      src_o     = SRC_AUX;
    end else begin
      kb_prev_o = rd_req_i;
      src_o     = SRC_REPLAY;
    end
  end

  // R2
  always_comb begin
    pick_onehot_chk: assert ($onehot0({kb_pop_o, aux_pop_o, kb_prev_o}));
  end
endmodule

// File: rtl/kbd_dual_rx_port.sv
module kbd_dual_rx_port
  import kbdq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_push_i,
  input  logic [DATA_W-1:0] kb_data_i,
  input  logic              aux_push_i,
  input  logic [DATA_W-1:0] aux_data_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        rd_src_o
);
  logic [NUM_QUEUES-1:0] q_push, q_pop, q_prev, q_empty;
  logic [DATA_W-1:0]     q_wdata [NUM_QUEUES];
  logic [DATA_W-1:0]     q_rdata [NUM_QUEUES];
  kbdq_src_e             src_d, src_q;

  assign q_push[Q_KBD]  = kb_push_i;
  assign q_push[Q_AUX]  = aux_push_i;
  assign q_wdata[Q_KBD] = kb_data_i;
  assign q_wdata[Q_AUX] = aux_data_i;
  assign q_prev[Q_AUX]  = 1'b0;

  kbdq_pick u_pick (
    .rd_req_i    (rd_req_i),
    .kb_empty_i  (q_empty[Q_KBD]),
    .aux_empty_i (q_empty[Q_AUX]),
    .kb_pop_o    (q_pop[Q_KBD]),
    .aux_pop_o   (q_pop[Q_AUX]),
    .kb_prev_o   (q_prev[Q_KBD]),
    .src_o       (src_d)
  );

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    kbdq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
      .clk         (clk),
      .rst         (rst),
      .push_i      (q_push[q]),
      .push_data_i (q_wdata[q]),
      .pop_i       (q_pop[q]),
      .peek_prev_i (q_prev[q]),
      .empty_o     (q_empty[q]),
      .rd_data_o   (q_rdata[q])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      src_q      <= SRC_KBD;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) src_q <= src_d;
    end
  end

  assign rd_src_o  = src_q;
  assign rd_data_o = (src_q == SRC_AUX) ? q_rdata[Q_AUX] : q_rdata[Q_KBD];

  // R10
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_i |=> rd_valid_o);

  // R10
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req_i |=> !rd_valid_o);

  // R3
  kb_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && !q_empty[Q_KBD]) |=> (rd_src_o == 2'd0));

  // R4
  replay_when_dry_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && q_empty[Q_KBD] && q_empty[Q_AUX]) |=> (rd_src_o == 2'd2));

  // R6
  replay_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && rd_src_o == 2'd2 && rd_req_i && q_empty[Q_KBD] && q_empty[Q_AUX])
      |=> $stable(rd_data_o));
endmodule

// File: tb/kbd_dual_rx_port_tb.sv
module kbd_dual_rx_port_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kb_push = 1'b0, aux_push = 1'b0, rd_req = 1'b0;
  logic [7:0] kb_data = '0, aux_data = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [1:0] rd_src;

  int checks = 0;
  int errors = 0;

  kbd_dual_rx_port #(.DEPTH(DEPTH), .DATA_W(8)) u_dut (
    .clk(clk), .rst(rst),
    .kb_push_i(kb_push), .kb_data_i(kb_data),
    .aux_push_i(aux_push), .aux_data_i(aux_data),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .rd_src_o(rd_src)
  );

  always #5 clk = ~clk;

  // reference model and scoreboard
  logic [7:0] kb_m[$];
  logic [7:0] aux_m[$];
  logic [7:0] kb_last = '0;
  bit         kb_last_ok = 0;
  int         kb_pops = 0;
  logic [1:0] exp_src[$];
  logic [7:0] exp_data[$];
  bit         exp_dchk[$];
  string      exp_tag[$];

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  task automatic step(input bit kv, input logic [7:0] kd, input bit av,
                      input logic [7:0] ad, input bit rd, input string tag);
    @(negedge clk);
    kb_push = kv; kb_data = kd; aux_push = av; aux_data = ad; rd_req = rd;
    if (rd) begin
      exp_tag.push_back(tag);
      if (kb_m.size() > 0) begin
        kb_last = kb_m.pop_front();
        kb_last_ok = 1;
        kb_pops++;
        exp_src.push_back(2'd0); exp_data.push_back(kb_last); exp_dchk.push_back(1);
      end else if (aux_m.size() > 0) begin
        exp_src.push_back(2'd1); exp_data.push_back(aux_m.pop_front()); exp_dchk.push_back(1);
      end else begin
        exp_src.push_back(2'd2); exp_data.push_back(kb_last); exp_dchk.push_back(kb_last_ok);
      end
    end
    if (kv && kb_m.size() < DEPTH) kb_m.push_back(kd);
    if (av && aux_m.size() < DEPTH) aux_m.push_back(ad);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, 0, "");
  endtask

  task automatic rd(input string tag);
    step(0, 8'h00, 0, 8'h00, 1, tag);
  endtask

  // monitor: results are due one edge after the request
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (exp_src.size() > 0) begin
        logic [1:0] es;
        logic [7:0] ed;
        bit         dc;
        string      tg;
        es = exp_src.pop_front(); ed = exp_data.pop_front();
        dc = exp_dchk.pop_front(); tg = exp_tag.pop_front();
        check(rd_valid == 1'b1, {tg, " R10 valid"}, rd_valid, 1);
        check(rd_src == es, {tg, " source"}, rd_src, es);
        if (dc) check(rd_data == ed, {tg, " data"}, rd_data, ed);
      end else if (rd_valid) begin
        check(0, "R10 valid without request", rd_valid, 0);
      end
    end
  end

  initial begin
    #1_000_000;
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 valid low after reset", rd_valid, 0);
    rd("R1 empty after reset gives repeat source");

    // R2 R7 keyboard order
    for (int i = 0; i < 3; i++) step(1, 8'h10 + 8'(i), 0, 8'h00, 0, "");
    for (int i = 0; i < 3; i++) rd("R2 R7 keyboard byte");
    // R4 R6 repeat reads
    rd("R4 repeat last keyboard byte");
    rd("R6 second repeat same byte");
    idle(1);
    step(1, 8'h21, 0, 8'h00, 0, "");
    rd("R6 pointer held after repeat");

    // R3 auxiliary path and priority
    step(0, 8'h00, 1, 8'hA1, 0, "");
    step(0, 8'h00, 1, 8'hA2, 0, "");
    rd("R3 aux when keyboard empty");
    step(1, 8'h31, 0, 8'h00, 1, "R3 same-cycle kb push unseen");
    step(0, 8'h00, 1, 8'hA3, 0, "");
    rd("R3 keyboard wins over aux");
    rd("R3 aux after keyboard drained");
    rd("R4 repeat after aux drain");

    // R5 drive keyboard read pointer to 0, then repeat
    begin
      int k;
      k = DEPTH - (kb_pops % DEPTH);
      for (int i = 0; i < k; i++) step(1, 8'h50 + 8'(i), 0, 8'h00, 0, "");
      for (int i = 0; i < k; i++) rd("R7 wrap order");
    end
    rd("R5 repeat at pointer zero");

    // R8 overflow dropped
    for (int i = 0; i <= DEPTH; i++) step(1, 8'h80 + 8'(i), 0, 8'h00, 0, "");
    for (int i = 0; i <= DEPTH; i++) rd("R8 full push dropped");

    // R9 push with pop on a full queue
    for (int i = 0; i < DEPTH; i++) step(1, 8'hC0 + 8'(i), 0, 8'h00, 0, "");
    step(1, 8'hE0, 0, 8'h00, 1, "R9 pop with push");
    step(1, 8'hE1, 0, 8'h00, 0, "");
    for (int i = 0; i <= DEPTH; i++) rd("R9 count unchanged");

    idle(4);
    check(exp_src.size() == 0, "R10 all reads answered", exp_src.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule